// File: doc/BRIEF.md
# Sub-frame plane input buffer

This block sits between a frame memory that delivers one pixel word per clock and a processing array that consumes a whole square plane of SIDE×SIDE words at once. Each incoming word is steered into one of SIDE² small first-in first-out queues. The queue is chosen by the word's position inside the current plane. The position runs in row-major order, x fastest. When every queue has at least one entry, the heads of all queues together form one plane. A single request from the array pops every queue in the same cycle.

Two status outputs close the loop. One tells the upstream address generator to stop, because every queue is full. The other tells the array that a complete cube of SIDE planes, SIDE³ words, is waiting. Each queue is 2·SIDE deep, so a second cube can be loaded while the first one is read out. All logic runs on one clock.

Top module: `subfr_ibuf`

## Requirements
- R1: After reset every queue is empty, `full`, `rd_ready` and `wr_drop` are low, and the write position is lane 0.
- R2: An accepted word is appended to the queue at the current write position p, with p = y·SIDE + x. The head of queue p appears on `plane_data[p*W +: W]`.
- R3: The write position advances by one on every accepted word and wraps from SIDE²−1 back to 0. A dropped word does not advance it.
- R4: `full` is high exactly when every queue holds 2·SIDE entries. While `full` is high and no pop occurs, it stays high.
- R5: A word offered while its target queue is full is discarded. `wr_drop` is high in that same cycle, and the queue contents are unchanged.
- R6: `rd_ready` is high exactly when every queue holds at least SIDE entries. The first time this happens is after the first SIDE³ accepted words.
- R7: `rd_req` in a cycle where every queue is non-empty removes one entry from every queue at that clock edge. The following plane is on `plane_data` in the next cycle.
- R8: `rd_req` in a cycle where any queue is empty has no effect on any queue.
- R9: Each lane of `plane_data` delivers its words in the order they were accepted.
- R10: A push and a pop in the same cycle both take effect. The push is judged against the occupancy before the pop, so a full queue still drops the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel word is offered this cycle |
| in_data | input | W | Pixel word |
| rd_req | input | 1 | Array requests the next plane |
| plane_data | output | SIDE·SIDE·W | Heads of all queues, lane p at bits p·W upward |
| full | output | 1 | Every queue is full; stall the address generator |
| rd_ready | output | 1 | A whole cube is buffered |
| wr_drop | output | 1 | The word offered this cycle was discarded |

## Verification
The assertions assume that words only enter through `in_valid` and leave only through a common pop. Under that assumption the queue occupancies never differ by more than one, and a drop can only happen when every queue is full. The stimulus respects this because the bench never bypasses the block's own ports.

Random phases offer words and requests at independent rates, so the buffer repeatedly fills, stalls and drains. Directed steps force the block to:
- hit the exact full boundary,
- offer a word while full, with and without a simultaneous pop,
- issue a request while the queues are empty.

// File: rtl/subfr_pkg.sv
package subfr_pkg;

    typedef struct packed {
        logic all_full;
        logic cube_ready;
        logic all_busy;
    } subfr_status_t;

    function automatic int unsigned lanes_of(input int unsigned side);
        return side * side;
    endfunction

    function automatic int unsigned depth_of(input int unsigned side);
        return 2 * side;
    endfunction

endpackage

// File: rtl/subfr_fifo.sv
module subfr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          is_full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign is_full = (cnt == CW'(DEPTH));
    assign push_ok = push && !is_full;
    assign pop_ok  = pop && (cnt != '0);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/subfr_steer.sv
module subfr_steer #(
    parameter int LANES = 16,
    localparam int SW   = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES-1:0] lane_full,
    output logic [LANES-1:0] wr_en,
    output logic             drop
);
    logic [SW-1:0] pos;
    logic          accept;

    assign drop   = in_valid && lane_full[pos];
    assign accept = in_valid && !lane_full[pos];

    for (genvar i = 0; i < LANES; i++) begin : g_sel
        assign wr_en[i] = accept && (pos == SW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) pos <= '0;
        else if (accept) pos <= (pos == SW'(LANES - 1)) ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/subfr_status.sv
module subfr_status
    import subfr_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    parameter int NEED  = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [LANES-1:0][CW-1:0] cnt,
    output subfr_status_t            st
);
    logic [LANES-1:0] at_top, has_cube, has_one;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign at_top[i]   = (cnt[i] == CW'(DEPTH));
        assign has_cube[i] = (cnt[i] >= CW'(NEED));
        assign has_one[i]  = (cnt[i] != '0);
    end

    always_comb begin
        st.all_full   = &at_top;
        st.cube_ready = &has_cube;
        st.all_busy   = &has_one;
    end
endmodule

// File: rtl/subfr_ibuf.sv
module subfr_ibuf
    import subfr_pkg::*;
#(
    parameter int SIDE  = 4,
    parameter int W     = 16,
    localparam int LANES = lanes_of(SIDE),
    localparam int DEPTH = depth_of(SIDE),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [W-1:0]       in_data,
    input  logic               rd_req,
    output logic [LANES*W-1:0] plane_data,
    output logic               full,
    output logic               rd_ready,
    output logic               wr_drop
);
    logic [LANES-1:0]         wr_en;
    logic [LANES-1:0]         lane_full;
    logic [LANES-1:0][CW-1:0] fifo_cnt;
    subfr_status_t            st;
    logic                     pop_all;

    subfr_steer #(.LANES(LANES)) u_steer (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .lane_full(lane_full), .wr_en(wr_en), .drop(wr_drop)
    );

    assign pop_all = rd_req && st.all_busy;

    for (genvar i = 0; i < LANES; i++) begin : g_q
        subfr_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst(rst),
            .push(wr_en[i]), .pop(pop_all), .din(in_data),
            .head(plane_data[i*W +: W]), .cnt(fifo_cnt[i]),
            .is_full(lane_full[i])
        );
    end

    subfr_status #(.LANES(LANES), .DEPTH(DEPTH), .NEED(SIDE)) u_status (
        .cnt(fifo_cnt), .st(st)
    );

    assign full     = st.all_full;
    assign rd_ready = st.cube_ready;
endmodule

// File: rtl/subfr_ibuf_chk.sv
module subfr_ibuf_chk #(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    parameter int NEED  = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_req,
    input logic                     full,
    input logic                     rd_ready,
    input logic                     wr_drop,
    input logic [LANES-1:0]         wr_en,
    input logic [LANES-1:0][CW-1:0] cnt
);
    a_r2_one_lane_written: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    a_r5_drop_only_when_full: assert property (@(posedge clk) disable iff (rst)
        wr_drop |-> full);

    a_r5_drop_writes_nothing: assert property (@(posedge clk) disable iff (rst)
        wr_drop |-> (wr_en == '0));

    a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_req) |=> full);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        a_r4_full_lane_top: assert property (@(posedge clk) disable iff (rst)
            full |-> (int'(cnt[i]) == DEPTH));

        a_r6_ready_lane_cube: assert property (@(posedge clk) disable iff (rst)
            rd_ready |-> (int'(cnt[i]) >= NEED));

        a_r3_lanes_balanced: assert property (@(posedge clk) disable iff (rst)
            (int'(cnt[i]) <= int'(cnt[0])) && (int'(cnt[0]) <= int'(cnt[i]) + 1));
    end
endmodule

bind subfr_ibuf subfr_ibuf_chk #(.LANES(LANES), .DEPTH(DEPTH), .NEED(SIDE)) u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .full(full), .rd_ready(rd_ready),
    .wr_drop(wr_drop), .wr_en(wr_en), .cnt(fifo_cnt)
);

// File: tb/tb_subfr_ibuf.sv
module tb_subfr_ibuf;
    localparam int SIDE  = 4;
    localparam int W     = 16;
    localparam int LANES = SIDE * SIDE;
    localparam int DEPTH = 2 * SIDE;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [W-1:0]       in_data = '0;
    logic               rd_req = 1'b0;
    logic [LANES*W-1:0] plane_data;
    logic               full, rd_ready, wr_drop;

    subfr_ibuf #(.SIDE(SIDE), .W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .rd_req(rd_req), .plane_data(plane_data), .full(full),
        .rd_ready(rd_ready), .wr_drop(wr_drop)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] mmem [LANES][DEPTH];
    int mhead [LANES];
    int mcnt  [LANES];
    int mpos;
    logic [W-1:0] word;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_all(input int thr);
        for (int p = 0; p < LANES; p++) if (mcnt[p] < thr) return 0;
        return 1;
    endfunction

    task automatic check_state(input string tag);
        chk(full == m_all(DEPTH), "R4 full", full, m_all(DEPTH));
        chk(rd_ready == m_all(SIDE), "R6 rd_ready", rd_ready, m_all(SIDE));
        for (int p = 0; p < LANES; p++) begin
            if (mcnt[p] > 0)
                chk(plane_data[p*W +: W] == mmem[p][mhead[p]], tag,
                    plane_data[p*W +: W], mmem[p][mhead[p]]);
        end
    endtask

    // one cycle: drive at negedge, predict, then compare at the next negedge
    task automatic cyc(input bit v, input logic [W-1:0] d, input bit r, input string tag);
        bit exp_drop, do_pop, do_push;
        in_valid = v; in_data = d; rd_req = r;
        #1;
        exp_drop = v && (mcnt[mpos] == DEPTH);
        chk(wr_drop == exp_drop, "R5 wr_drop", wr_drop, exp_drop);
        do_pop  = r && m_all(1);
        do_push = v && !exp_drop;
        if (do_push) begin
            mmem[mpos][(mhead[mpos] + mcnt[mpos]) % DEPTH] = d;
            mcnt[mpos]++;
            mpos = (mpos + 1) % LANES;
        end
        if (do_pop) begin
            for (int p = 0; p < LANES; p++) begin
                mhead[p] = (mhead[p] + 1) % DEPTH;
                mcnt[p]--;
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rd_req = 1'b0;
        check_state(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < LANES; p++) begin mhead[p] = 0; mcnt[p] = 0; end
        mpos = 0;
        word = 16'h0100;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: empty after reset
        chk(full == 1'b0, "R1 full", full, 0);
        chk(rd_ready == 1'b0, "R1 rd_ready", rd_ready, 0);
        chk(wr_drop == 1'b0, "R1 wr_drop", wr_drop, 0);
        @(negedge clk);

        // R2 R3: first plane fills lanes in order, then wraps to lane 0
        for (int k = 0; k < LANES + 1; k++) begin cyc(1, word, 0, "R2_R3 lane"); word++; end
        // R6: ready only after SIDE^3 words
        for (int k = LANES + 1; k < LANES * SIDE; k++) begin cyc(1, word, 0, "R2 lane"); word++; end
        chk(rd_ready == 1'b1, "R6 cube", rd_ready, 1);
        // R4: fill to full
        for (int k = 0; k < LANES * SIDE; k++) begin cyc(1, word, 0, "R2 lane"); word++; end
        chk(full == 1'b1, "R4 all full", full, 1);
        // R5: write while full dropped, state unchanged
        cyc(1, 16'hDEAD, 0, "R5 unchanged");
        // R10: write with pop at full still dropped, pop happens
        cyc(1, 16'hBEEF, 1, "R10 push_pop");
        chk(full == 1'b0, "R10 pop", full, 0);
        // R3: dropped words did not move the position, next word refills lane 0
        cyc(1, word, 0, "R3 lane0"); word++;
        // R7 R9: drain everything in order
        for (int k = 0; k < 3 * DEPTH; k++) cyc(0, 0, 1, "R7_R9 drain");
        chk(rd_ready == 1'b0, "R7 drained", rd_ready, 0);
        // R8: request while some queue empty does nothing
        cyc(0, 0, 1, "R8 empty_req");
        cyc(1, word, 1, "R8 partial_req"); word++;
        cyc(0, 0, 1, "R8 partial_req");

        // random phases with various rates
        for (int ph = 0; ph < 4; ph++) begin
            for (int k = 0; k < 2500; k++) begin
                bit v, r;
                v = ($urandom % 100) < (ph == 1 ? 90 : 55);
                r = ($urandom % 100) < (ph == 2 ? 70 : 8 + 2 * ph);
                cyc(v, W'($urandom), r, "R9 random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule